// File: doc/BRIEF.md
# I2C Master Receive-Hold Command and Interrupt Unit

This block is the command and interrupt-status front end for one channel of an I2C master. Software programs it through four word-wide registers: a command word, a write-one-to-clear interrupt status word, an interrupt enable word and a data buffer. The command word carries start, receive, receive-last and stop flags. A receive flag asks the bit engine for one byte. The engine itself is outside the block and is reached through a request/ready handshake that returns a data byte and an error flag.

The receive-done status bit also controls the flow of received data. While it is set, a pending receive command is held and the bit engine is not asked for another byte. When software clears the bit, the held receive starts by itself, and the interrupt comes back when that byte arrives. A per-channel summary bit for the controller-level interrupt summary is kept alongside the interrupt output. Software can drop this summary bit only by leaving the channel's whole status word empty.

Top module: `i2cm_rxhold_top`

## Requirements
- R1: After reset the command, status, enable and buffer registers read zero, and irqOut, chanSummary, rxReq and rxNack are low.
- R2: A write to the command register (address 0) stores only write-data bits 15:0. Bits 31:16 of the written word have no effect: the readback of bits 31:16 shows only the channel state field.
- R3: A command-register write clears every status bit except receive-done (status bit 2), which keeps its value. A hardware event arriving in the same cycle is still recorded.
- R4: A command holding the receive flag (bit 3) or the receive-last flag (bit 4) raises rxReq two clock edges after the write, but only while status bit 2 is clear. If bit 2 is set, the command stays pending and rxReq stays low.
- R5: The status register (address 1) is write-one-to-clear over bits 14:0. Written bits 31:15 are ignored.
- R6: When a status write clears bit 2 while a receive command is pending, rxReq rises two edges later. Completion of that byte sets bit 2 again and sets chanSummary.
- R7: A status write lowers chanSummary only if all 15 status bits are zero after the write. Otherwise chanSummary stays high.
- R8: A byte accepted with rxReady and no rxError sets status bit 2 and is placed in buffer bits 15:8 (address 3). A byte with rxError leaves bit 2 unchanged and puts 0xFF in bits 15:8.
- R9: rxNack is high during a read issued by a receive-last command. Once the byte is handled, command bits 3 and 4 read zero.
- R10: Command readback bits 19:16 give the channel state: 0 idle, 1 master active (after a start flag, bit 0), 2 receiving data while rxReq is high. After a read in an active channel the field returns to 1.
- R11: The enable register (address 2) holds 15 bits. irqOut is high exactly when some status bit and its enable bit are both set.
- R12: A status bit that hardware sets in the same cycle as a write of one to that bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 command, 1 status, 2 enable, 3 buffer |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Combinational readback of the selected register |
| hwEvent | input | 15 | One-cycle status event pulses from the rest of the channel |
| rxReq | output | 1 | Byte read request to the bit engine |
| rxNack | output | 1 | NACK the current byte (receive-last) |
| rxReady | input | 1 | Bit engine has finished the requested byte |
| rxData | input | 8 | Received byte |
| rxError | input | 1 | The byte read failed |
| irqOut | output | 1 | Channel interrupt |
| chanSummary | output | 1 | Channel bit for the controller interrupt summary |

## Verification
The receive path is exercised in three ways: a plain receive with receive-done clear, a second receive issued while receive-done is still set, and a receive-last that ends in a bit-engine error. These separate immediate issue, deferred issue and the no-status error path. Status writes are tried with only high bits set, with a partial clear that leaves another event pending, and with a full clear. These show the ignored bits and the difference between the summary bit and the enable-gated interrupt. A write that collides with a hardware event on the same bit checks that the event is not lost.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int REG_W      = 32;
  localparam int CMD_W      = 16;
  localparam int STAT_W     = 15;
  localparam int BYTE_W     = 8;
  localparam int ADDR_W     = 2;
  localparam int STATE_W    = 4;
  localparam int BUF_SHIFT  = 8;

  localparam int RXDONE_BIT = 2;
  localparam int CMD_START  = 0;
  localparam int CMD_RX     = 3;
  localparam int CMD_RXLAST = 4;
  localparam int CMD_STOP   = 5;

  localparam logic [ADDR_W-1:0] A_CMD  = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_EN   = 2'd2;
  localparam logic [ADDR_W-1:0] A_BUF  = 2'd3;

  localparam logic [STATE_W-1:0] ST_IDLE   = 4'd0;
  localparam logic [STATE_W-1:0] ST_ACTIVE = 4'd1;
  localparam logic [STATE_W-1:0] ST_RXDATA = 4'd2;

  typedef struct packed {
    logic rxBusy;
    logic rxFinish;
  } rxStrobe_t;
endpackage

// File: rtl/i2cm_rx_ctrl.sv
module i2cm_rx_ctrl
  import i2cm_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      rxPending,
  input  logic      rxHold,
  input  logic      rxReady,
  output rxStrobe_t strb
);
  logic busyQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
    end else if (!busyQ) begin
      if (rxPending && !rxHold) busyQ <= 1'b1;
    end else if (rxReady) begin
      busyQ <= 1'b0;
    end
  end

  always_comb begin
    strb.rxBusy   = busyQ;
    strb.rxFinish = busyQ && rxReady;
  end
endmodule

// File: rtl/i2cm_rx_regs.sv
module i2cm_rx_regs
  import i2cm_pkg::*;
#(
  parameter int RW = REG_W,
  parameter int CW = CMD_W,
  parameter int SW = STAT_W,
  parameter int BW = BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [RW-1:0]     wrData,
  input  logic [SW-1:0]     hwEvent,
  input  logic [BW-1:0]     rxData,
  input  logic              rxError,
  input  rxStrobe_t         strb,
  output logic [RW-1:0]     rdData,
  output logic [SW-1:0]     statusQ,
  output logic [SW-1:0]     enableQ,
  output logic [CW-1:0]     cmdQ,
  output logic              summaryQ,
  output logic              rxPending,
  output logic              rxHold,
  output logic              rxNack
);
  localparam int PAD_CMD = RW - CW - STATE_W;
  localparam int PAD_BUF = RW - BW - BUF_SHIFT;

  logic              activeQ;
  logic [BW-1:0]     byteQ;
  logic [SW-1:0]     statusD;
  logic [SW-1:0]     setMask;
  logic [SW-1:0]     clrMask;
  logic              cmdWr, statWr, enWr;
  logic [STATE_W-1:0] stateField;
  logic [RW-CW-1:0]  unusedHighBits;

  assign unusedHighBits = wrData[RW-1:CW];
  assign cmdWr  = wrEn && (addr == A_CMD);
  assign statWr = wrEn && (addr == A_STAT);
  assign enWr   = wrEn && (addr == A_EN);

  always_comb begin
    setMask = hwEvent;
    setMask[RXDONE_BIT] = hwEvent[RXDONE_BIT] | (strb.rxFinish & ~rxError);
    clrMask = statWr ? wrData[SW-1:0] : '0;
  end

  for (genvar i = 0; i < SW; i++) begin : g_stat
    if (i == RXDONE_BIT) begin : g_hold
      assign statusD[i] = setMask[i] | (statusQ[i] & ~clrMask[i]);
    end else begin : g_plain
      assign statusD[i] = setMask[i] | (statusQ[i] & ~clrMask[i] & ~cmdWr);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ  <= '0;
      enableQ  <= '0;
      cmdQ     <= '0;
      activeQ  <= 1'b0;
      byteQ    <= '0;
      summaryQ <= 1'b0;
    end else begin
      statusQ <= statusD;
      if (enWr) enableQ <= wrData[SW-1:0];
      if (cmdWr) begin
        cmdQ <= wrData[CW-1:0];
        if (wrData[CMD_STOP])       activeQ <= 1'b0;
        else if (wrData[CMD_START]) activeQ <= 1'b1;
      end else if (strb.rxFinish) begin
        cmdQ[CMD_RX]     <= 1'b0;
        cmdQ[CMD_RXLAST] <= 1'b0;
      end
      if (strb.rxFinish) byteQ <= rxError ? '1 : rxData;
      if (|setMask)                      summaryQ <= 1'b1;
      else if (statWr && statusD == '0)  summaryQ <= 1'b0;
    end
  end

  always_comb begin
    if (strb.rxBusy)  stateField = ST_RXDATA;
    else if (activeQ) stateField = ST_ACTIVE;
    else              stateField = ST_IDLE;
  end

  assign rxPending = cmdQ[CMD_RX] | cmdQ[CMD_RXLAST];
  assign rxHold    = statusQ[RXDONE_BIT];
  assign rxNack    = strb.rxBusy & cmdQ[CMD_RXLAST];

  always_comb begin
    case (addr)
      A_CMD:   rdData = {{PAD_CMD{1'b0}}, stateField, cmdQ};
      A_STAT:  rdData = {{(RW-SW){1'b0}}, statusQ};
      A_EN:    rdData = {{(RW-SW){1'b0}}, enableQ};
      default: rdData = {{PAD_BUF{1'b0}}, byteQ, {BUF_SHIFT{1'b0}}};
    endcase
  end
endmodule

// File: rtl/i2cm_rxhold_top.sv
module i2cm_rxhold_top
  import i2cm_pkg::*;
#(
  parameter int RW = REG_W,
  parameter int SW = STAT_W,
  parameter int BW = BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [RW-1:0]     regWrData,
  output logic [RW-1:0]     regRdData,
  input  logic [SW-1:0]     hwEvent,
  output logic              rxReq,
  output logic              rxNack,
  input  logic              rxReady,
  input  logic [BW-1:0]     rxData,
  input  logic              rxError,
  output logic              irqOut,
  output logic              chanSummary
);
  rxStrobe_t        strb;
  logic [SW-1:0]    statusQ, enableQ;
  logic [CMD_W-1:0] cmdQ;
  logic             rxPending, rxHold;

  i2cm_rx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rxPending(rxPending), .rxHold(rxHold),
    .rxReady(rxReady), .strb(strb)
  );

  i2cm_rx_regs #(.RW(RW), .CW(CMD_W), .SW(SW), .BW(BW)) u_regs (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .addr(regAddr), .wrData(regWrData),
    .hwEvent(hwEvent), .rxData(rxData), .rxError(rxError), .strb(strb),
    .rdData(regRdData), .statusQ(statusQ), .enableQ(enableQ), .cmdQ(cmdQ),
    .summaryQ(chanSummary), .rxPending(rxPending), .rxHold(rxHold), .rxNack(rxNack)
  );

  assign rxReq  = strb.rxBusy;
  assign irqOut = |(statusQ & enableQ);
endmodule

// File: rtl/i2cm_rxhold_chk.sv
module i2cm_rxhold_chk
  import i2cm_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [REG_W-1:0]  regWrData,
  input logic [STAT_W-1:0] hwEvent,
  input logic              rxReq,
  input logic              rxNack,
  input logic              rxReady,
  input logic              irqOut,
  input logic              chanSummary,
  input logic [STAT_W-1:0] statusQ,
  input logic [CMD_W-1:0]  cmdQ
);
  p_rx_blocked_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxReq) |-> !$past(statusQ[RXDONE_BIT]));

  p_rxdone_kept_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == A_CMD && !rxReq && !hwEvent[RXDONE_BIT])
      |=> statusQ[RXDONE_BIT] == $past(statusQ[RXDONE_BIT]));

  p_high_ignored_r5: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == A_STAT && regWrData[STAT_W-1:0] == '0 &&
     hwEvent == '0 && !(rxReq && rxReady)) |=> $stable(statusQ));

  p_sum_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(chanSummary) |-> statusQ == '0);

  p_nack_in_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    rxNack |-> rxReq);

  p_flags_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rxReq && rxReady && !regWrEn) |=> (!cmdQ[CMD_RX] && !cmdQ[CMD_RXLAST]));

  p_irq_source_r11: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> statusQ != '0);

  p_set_wins_r12: assert property (@(posedge clk) disable iff (!rstN)
    (hwEvent != '0) |=> ((statusQ & $past(hwEvent)) == $past(hwEvent)));
endmodule

bind i2cm_rxhold_top i2cm_rxhold_chk u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .hwEvent(hwEvent), .rxReq(rxReq), .rxNack(rxNack),
  .rxReady(rxReady), .irqOut(irqOut), .chanSummary(chanSummary),
  .statusQ(statusQ), .cmdQ(cmdQ)
);

// File: tb/tb_i2cm_rxhold_top.sv
module tb_i2cm_rxhold_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [14:0] hwEvent = '0;
  logic        rxReq, rxNack, irqOut, chanSummary;
  logic        rxReady = 1'b0;
  logic [7:0]  rxData = '0;
  logic        rxError = 1'b0;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  typedef struct {
    int          src;
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t sbq[$];

  always #2 clk = ~clk;

  i2cm_rxhold_top dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .hwEvent(hwEvent),
    .rxReq(rxReq), .rxNack(rxNack), .rxReady(rxReady), .rxData(rxData),
    .rxError(rxError), .irqOut(irqOut), .chanSummary(chanSummary)
  );

  // monitor: compares queued expectations at the falling edge
  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sbq.pop_front();
      case (it.src)
        0: act = regRdData;
        1: act = {31'd0, irqOut};
        2: act = {31'd0, chanSummary};
        3: act = {31'd0, rxReq};
        default: act = {31'd0, rxNack};
      endcase
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s src=%0d actual=0x%08h expected=0x%08h", it.req, it.src, act, it.exp);
      end
    end
  end

  task automatic expectVal(input int src, input logic [1:0] a, input logic [31:0] e, input string r);
    item_t it;
    @(posedge clk); #1;
    regAddr = a;
    it.src = src; it.exp = e; it.req = r;
    sbq.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic pulseEvent(input logic [14:0] v);
    @(posedge clk); #1; hwEvent = v;
    @(posedge clk); #1; hwEvent = '0;
  endtask

  task automatic finishByte(input logic [7:0] d, input logic err);
    wait (rxReq === 1'b1);
    @(posedge clk); #1;
    rxReady = 1'b1; rxData = d; rxError = err;
    @(posedge clk); #1;
    rxReady = 1'b0; rxError = 1'b0;
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    waitEdges(3);
    rstN = 1'b1;
    // R1 reset state
    expectVal(0, 2'd0, 32'h0, "R1 cmd");
    expectVal(0, 2'd1, 32'h0, "R1 status");
    expectVal(0, 2'd2, 32'h0, "R1 enable");
    expectVal(0, 2'd3, 32'h0, "R1 buffer");
    expectVal(1, 2'd0, 32'h0, "R1 irq");
    expectVal(2, 2'd0, 32'h0, "R1 summary");
    expectVal(3, 2'd0, 32'h0, "R1 rxReq");
    expectVal(4, 2'd0, 32'h0, "R1 rxNack");

    // R11 enable width
    regWrite(2'd2, 32'hFFFF_FFFF);
    expectVal(0, 2'd2, 32'h0000_7FFF, "R11 enable 15 bits");

    // R2 / R10 start with junk in high half
    regWrite(2'd0, 32'hABCD_0001);
    expectVal(0, 2'd0, 32'h0001_0001, "R2 R10 cmd high ignored, active");

    // R11 event raises irq and summary
    pulseEvent(15'h0020);
    expectVal(0, 2'd1, 32'h20, "R11 status event");
    expectVal(1, 2'd0, 32'h1, "R11 irq");
    expectVal(2, 2'd0, 32'h1, "R11 summary");

    // R3 / R4 first receive
    regWrite(2'd0, 32'h0000_0009);
    expectVal(0, 2'd1, 32'h0, "R3 cmd write clears status");
    expectVal(1, 2'd0, 32'h0, "R3 irq low");
    waitEdges(2);
    expectVal(3, 2'd0, 32'h1, "R4 rxReq issued");
    expectVal(0, 2'd0, 32'h0002_0009, "R10 state receiving");
    finishByte(8'h5A, 1'b0);
    expectVal(0, 2'd1, 32'h4, "R8 rx done set");
    expectVal(0, 2'd3, 32'h5A00, "R8 byte in buffer");
    expectVal(0, 2'd0, 32'h0001_0001, "R9 R10 flags cleared, active");
    expectVal(1, 2'd0, 32'h1, "R11 irq on rx done");

    // R3 / R4 second receive blocked while rx done set
    pulseEvent(15'h0080);
    regWrite(2'd0, 32'h0000_0009);
    expectVal(0, 2'd1, 32'h4, "R3 rx done kept");
    waitEdges(4);
    expectVal(3, 2'd0, 32'h0, "R4 blocked rxReq");
    expectVal(0, 2'd0, 32'h0001_0009, "R4 command pending");

    // R5 high bits ignored; R6 / R7 partial clear
    pulseEvent(15'h0200);
    regWrite(2'd1, 32'hFFFF_8000);
    expectVal(0, 2'd1, 32'h204, "R5 high bits ignored");
    regWrite(2'd1, 32'h0000_0004);
    expectVal(2, 2'd0, 32'h1, "R7 summary held");
    expectVal(1, 2'd0, 32'h1, "R11 irq held by other bit");
    waitEdges(1);
    expectVal(3, 2'd0, 32'h1, "R6 deferred read issued");
    finishByte(8'h33, 1'b0);
    expectVal(0, 2'd1, 32'h204, "R6 rx done set again");
    expectVal(0, 2'd3, 32'h3300, "R6 second byte");

    // R7 full clear
    regWrite(2'd1, 32'h0000_0204);
    expectVal(2, 2'd0, 32'h0, "R7 summary cleared");
    expectVal(1, 2'd0, 32'h0, "R7 irq cleared");

    // R8 / R9 receive-last with error
    regWrite(2'd0, 32'h0000_0011);
    waitEdges(2);
    expectVal(4, 2'd0, 32'h1, "R9 nack during last");
    finishByte(8'h12, 1'b1);
    expectVal(0, 2'd3, 32'hFF00, "R8 error buffer");
    expectVal(0, 2'd1, 32'h0, "R8 error no rx done");
    expectVal(0, 2'd0, 32'h0001_0001, "R9 last flag cleared");
    expectVal(4, 2'd0, 32'h0, "R9 nack low after");

    // R12 set wins over clear
    pulseEvent(15'h0008);
    @(posedge clk); #1;
    regWrEn = 1'b1; regAddr = 2'd1; regWrData = 32'h8; hwEvent = 15'h0008;
    @(posedge clk); #1;
    regWrEn = 1'b0; hwEvent = '0;
    expectVal(0, 2'd1, 32'h8, "R12 set kept");
    regWrite(2'd1, 32'h8);
    expectVal(0, 2'd1, 32'h0, "R12 later clear");

    // R11 enable gating
    regWrite(2'd2, 32'h0);
    pulseEvent(15'h0002);
    expectVal(1, 2'd0, 32'h0, "R11 disabled irq");
    expectVal(2, 2'd0, 32'h1, "R11 summary ungated");

    waitEdges(2);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule